// File: doc/BRIEF.md
# Multi-Mode Serial Port

This block is a serial port that a processor core drives through three registers: a control/status word, a data word and a baud reload word. Writing the data word starts a transmit frame. Reading the data word returns the last byte held in the receive latch. The two completion flags stay set until software writes a zero to them.

There are four modes, selected by the control word.

- **Mode 0** is a synchronous shift mode. It sends and receives 8 bits at once, under a shift clock of system clock / 4.
- **Modes 1 to 3** are asynchronous framed modes. Each frame has a start bit and a stop bit.
  - Mode 1 carries 8 data bits.
  - Modes 2 and 3 add a ninth bit.
- **Bit rates:**
  - Mode 2 runs at system clock / 64, or / 32 when the half-rate bit is set.
  - Modes 1 and 3 take their rate from a 16-bit reload counter.

The receiver oversamples the line 16 times per bit. It takes each bit as a majority vote of the 7th, 8th and 9th oversample ticks, and drops any start bit that is no longer low at mid-bit.

The transmit engine has these states:

| State | Meaning |
|---|---|
| TX_IDLE | Line idle |
| TX_ARM | Waiting for the next oversample tick |
| TX_START | Start bit |
| TX_DATA | Data bits |
| TX_NINTH | Ninth bit |
| TX_STOP | Stop bit |
| TX_SYNC | Mode 0 shift |

Its transitions are:
- IDLE to ARM on a data write in modes 1 to 3.
- IDLE to SYNC on a data write in mode 0.
- ARM to START on a tick.
- START to DATA after 16 ticks.
- DATA to NINTH or STOP after the last data bit.
- NINTH to STOP after 16 ticks.
- STOP to IDLE after 16 ticks.
- SYNC to IDLE after the eighth shift.

The receive engine has these states:

| State | Meaning |
|---|---|
| RX_IDLE | Waiting for a falling edge |
| RX_START | Start bit |
| RX_DATA | Data bits |
| RX_STOP | Stop bit |

Its transitions are:
- IDLE to START on a falling edge while reception is enabled and the mode is asynchronous.
- START back to IDLE on a false start.
- START to DATA after 16 ticks.
- DATA to STOP after 8 or 9 bits.
- STOP to IDLE at the mid-stop vote, where the byte is handed over.

Top module: `sport_ctrl`

## Requirements
- R1: After reset the line output and the shift clock are high, and the control, data and reload registers read 0.
- R2: In mode 0 (mode field 0, control bits 7:6), a data write shifts 8 bits LSB first on the line output. The shift clock has a 4-cycle period, low for 2 cycles and high for 2. The serial input is taken at each rising shift-clock edge. When reception is enabled the 8 sampled bits, LSB first, reach the data register, and the transmit flag is set.
- R3: An asynchronous frame is sent in this order: a low start bit, 8 data bits LSB first, then in modes 2 and 3 the ninth bit taken from control bit 3, then a high stop bit. The line is high when idle.
- R4: In modes 1 and 3 one bit lasts 16*(reload+1) clock cycles, where reload is register select 2. Reload 0 gives 16 cycles, the fastest rate. Line changes in these modes happen only on oversample ticks.
- R5: In mode 2 one bit lasts 64 cycles when control bit 5 is 0, and 32 cycles when it is 1.
- R6: The transmit flag (control bit 1) is set at the end of the stop bit, or after the eighth mode-0 shift. It stays set through later frames until software writes 0 to it. Writing 1 to it has no effect.
- R7: With reception enabled (control bit 4), a valid asynchronous frame is placed in the data register and the receive flag (control bit 0) is set. Each bit is a majority of three samples. The receive flag stays set until software writes 0 to it.
- R8: Control bit 2 takes the received ninth bit in modes 2 and 3, and the received stop bit in mode 1.
- R9: A frame that completes while the receive flag is set is discarded, and the data register and control bit 2 keep their values.
- R10: A low pulse on the serial input that is shorter than half a bit starts no reception. A valid frame that follows is received correctly.
- R11: With control bit 4 at 0, an asynchronous frame on the serial input is not received.
- R12: A data write while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 data, 2 reload |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read target: 0 control, 1 data, 2 reload |
| rd_data | output | 16 | Read data (combinational) |
| ser_in | input | 1 | Serial receive input |
| ser_out | output | 1 | Serial transmit output |
| sclk_o | output | 1 | Mode 0 shift clock, idle high |

## Verification
An asynchronous frame begins on an oversample tick. After the falling edge, every bit therefore lasts exactly one bit length, so the bench samples each bit half a bit length past its edge. The transmit flag is read four cycles after the stop bit ends, past its one-cycle handover.

The receive flag and the data register are due a cycle or two after the mid-stop vote, so the bench reads them once its driven frame is complete. In mode 0 the bench reads the line while the shift clock is high. It changes the serial input only after a falling shift-clock edge, which leaves the two synchronizer stages and the capture cycle room to settle.

// File: rtl/sport_pkg.sv
package sport_pkg;
    typedef enum logic [1:0] {
        MODE_SYNC   = 2'd0,
        MODE_A8     = 2'd1,
        MODE_A9_FIX = 2'd2,
        MODE_A9_PRG = 2'd3
    } smode_e;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_DATA   = 2'd1;
    localparam logic [1:0] SEL_RELOAD = 2'd2;

    localparam int OS_RATE = 16;
endpackage

// File: rtl/sport_baud.sv
module sport_baud #(
    parameter int RLW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RLW-1:0] reload,
    output logic           os_tick
);
    logic [RLW-1:0] cnt_q;

    assign os_tick = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (os_tick) cnt_q <= reload;
        else              cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/sport_tx.sv
module sport_tx
    import sport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  smode_e        mode,
    input  logic          os_tick,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          b8_in,
    input  logic          rx_line,
    output logic          ser_out,
    output logic          sclk_o,
    output logic          busy,
    output logic          tx_done,
    output logic          sync_done,
    output logic [DW-1:0] sync_byte
);
    localparam int BCW = $clog2(DW);

    typedef enum logic [2:0] {
        TX_IDLE, TX_ARM, TX_START, TX_DATA, TX_NINTH, TX_STOP, TX_SYNC
    } txst_e;

    txst_e          st_q, st_d;
    logic [3:0]     os_q;
    logic [1:0]     ph_q;
    logic [BCW-1:0] bit_q;
    logic [DW-1:0]  sh_q, rsh_q;
    logic           b8_q;

    logic bit_end, last_bit, ninth;
    assign bit_end  = os_tick && (os_q == 4'(OS_RATE - 1));
    assign last_bit = (bit_q == BCW'(DW - 1));
    assign ninth    = (mode == MODE_A9_FIX) || (mode == MODE_A9_PRG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (load) st_d = (mode == MODE_SYNC) ? TX_SYNC : TX_ARM;
            TX_ARM:   if (os_tick) st_d = TX_START;
            TX_START: if (bit_end) st_d = TX_DATA;
            TX_DATA:  if (bit_end && last_bit) st_d = ninth ? TX_NINTH : TX_STOP;
            TX_NINTH: if (bit_end) st_d = TX_STOP;
            TX_STOP:  if (bit_end) st_d = TX_IDLE;
            TX_SYNC:  if (ph_q == 2'd3 && last_bit) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q      <= '0;
            ph_q      <= '0;
            bit_q     <= '0;
            sh_q      <= '0;
            rsh_q     <= '0;
            b8_q      <= 1'b0;
            tx_done   <= 1'b0;
            sync_done <= 1'b0;
        end else begin
            tx_done   <= 1'b0;
            sync_done <= 1'b0;
            if (st_q == TX_IDLE && load) begin
                sh_q  <= din;
                b8_q  <= b8_in;
                bit_q <= '0;
                ph_q  <= '0;
            end
            if (st_q == TX_ARM || st_q == TX_IDLE) os_q <= '0;
            else if (os_tick)                      os_q <= os_q + 4'd1;
            if (st_q == TX_DATA && bit_end) begin
                sh_q  <= sh_q >> 1;
                bit_q <= bit_q + BCW'(1);
            end
            if (st_q == TX_STOP && bit_end) tx_done <= 1'b1;
            if (st_q == TX_SYNC) begin
                ph_q <= ph_q + 2'd1;
                if (ph_q == 2'd3) begin
                    sh_q  <= sh_q >> 1;
                    rsh_q <= {rx_line, rsh_q[DW-1:1]};
                    bit_q <= bit_q + BCW'(1);
                    if (last_bit) begin
                        tx_done   <= 1'b1;
                        sync_done <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        ser_out = 1'b1;
        sclk_o  = 1'b1;
        unique case (st_q)
            TX_START: ser_out = 1'b0;
            TX_DATA:  ser_out = sh_q[0];
            TX_NINTH: ser_out = b8_q;
            TX_SYNC:  begin ser_out = sh_q[0]; sclk_o = ph_q[1]; end
            default:  ser_out = 1'b1;
        endcase
    end

    assign busy      = (st_q != TX_IDLE);
    assign sync_byte = rsh_q;

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ((ser_out != $past(ser_out)) && ($past(st_q) != TX_SYNC) && (st_q != TX_SYNC))
        |-> $past(os_tick)) else $error("line moved off a tick"); // R4
endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  smode_e        mode,
    input  logic          en,
    input  logic          os_tick,
    input  logic          line,
    output logic          rx_done,
    output logic [DW-1:0] rx_byte,
    output logic          rx_b8
);
    localparam int BCW = $clog2(DW + 1);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxst_e;

    rxst_e          st_q, st_d;
    logic           line_d, sa_q, sb_q;
    logic [3:0]     os_q;
    logic [BCW-1:0] bit_q;
    logic [DW:0]    sh_q;

    logic ninth, vote, mid, bit_end;
    logic [BCW-1:0] nbits;
    assign ninth   = (mode == MODE_A9_FIX) || (mode == MODE_A9_PRG);
    assign nbits   = ninth ? BCW'(DW + 1) : BCW'(DW);
    assign vote    = (sa_q & sb_q) | (sa_q & line) | (sb_q & line);
    assign mid     = os_tick && (os_q == 4'd8);
    assign bit_end = os_tick && (os_q == 4'(OS_RATE - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:  if (en && mode != MODE_SYNC && line_d && !line) st_d = RX_START;
            RX_START: if (mid && vote) st_d = RX_IDLE;
                      else if (bit_end) st_d = RX_DATA;
            RX_DATA:  if (bit_end && bit_q == nbits) st_d = RX_STOP;
            RX_STOP:  if (mid) st_d = RX_IDLE;
            default:  st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_d  <= 1'b1;
            sa_q    <= 1'b1;
            sb_q    <= 1'b1;
            os_q    <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            rx_done <= 1'b0;
            rx_byte <= '0;
            rx_b8   <= 1'b0;
        end else begin
            line_d  <= line;
            rx_done <= 1'b0;
            if (st_q == RX_IDLE) begin
                os_q  <= '0;
                bit_q <= '0;
            end else if (os_tick) begin
                os_q <= os_q + 4'd1;
                if (os_q == 4'd6) sa_q <= line;
                if (os_q == 4'd7) sb_q <= line;
            end
            if (st_q == RX_DATA && mid) begin
                sh_q  <= {vote, sh_q[DW:1]};
                bit_q <= bit_q + BCW'(1);
            end
            if (st_q == RX_STOP && mid) begin
                rx_done <= 1'b1;
                rx_b8   <= ninth ? sh_q[DW] : vote;
                rx_byte <= ninth ? sh_q[DW-1:0] : sh_q[DW:1];
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done) else $error("receive hand-over held"); // R7
endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
    import sport_pkg::*;
#(
    parameter int DW    = 8,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             sclk_o
);
    smode_e           mode_q;
    logic             ri_q, ti_q, rb8_q, tb8_q, rxen_q, half_q;
    logic [REG_W-1:0] reload_q, os_reload;
    logic [DW-1:0]    rbuf_q;
    logic             s1_q, s2_q;

    logic          os_tick, tx_busy, tx_done, sync_done, rx_done, rx_b8;
    logic [DW-1:0] sync_byte, rx_byte;
    logic          wr_ctrl, wr_dat;

    assign wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
    assign wr_dat    = wr_en && (wr_sel == SEL_DATA);
    assign os_reload = (mode_q == MODE_A9_FIX) ? (half_q ? REG_W'(1) : REG_W'(3)) : reload_q;

    sport_baud #(.RLW(REG_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .reload(os_reload), .os_tick(os_tick));

    sport_tx #(.DW(DW)) tx_i (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .os_tick(os_tick), .load(wr_dat),
        .din(wr_data[DW-1:0]), .b8_in(tb8_q), .rx_line(s2_q), .ser_out(ser_out),
        .sclk_o(sclk_o), .busy(tx_busy), .tx_done(tx_done), .sync_done(sync_done),
        .sync_byte(sync_byte));

    sport_rx #(.DW(DW)) rx_i (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .en(rxen_q), .os_tick(os_tick),
        .line(s2_q), .rx_done(rx_done), .rx_byte(rx_byte), .rx_b8(rx_b8));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q     <= 1'b1;
            s2_q     <= 1'b1;
            mode_q   <= MODE_SYNC;
            {ri_q, ti_q, rb8_q, tb8_q, rxen_q, half_q} <= '0;
            reload_q <= '0;
            rbuf_q   <= '0;
        end else begin
            s1_q <= ser_in;
            s2_q <= s1_q;
            if (wr_ctrl) begin
                ri_q   <= ri_q & wr_data[0];
                ti_q   <= ti_q & wr_data[1];
                tb8_q  <= wr_data[3];
                rxen_q <= wr_data[4];
                half_q <= wr_data[5];
                mode_q <= smode_e'(wr_data[7:6]);
            end
            if (wr_en && wr_sel == SEL_RELOAD) reload_q <= wr_data;
            if (tx_done) ti_q <= 1'b1;
            if (rx_done && !ri_q) begin
                rbuf_q <= rx_byte;
                rb8_q  <= rx_b8;
                ri_q   <= 1'b1;
            end
            if (sync_done && rxen_q && !ri_q) begin
                rbuf_q <= sync_byte;
                ri_q   <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_CTRL:   rd_data = REG_W'({mode_q, half_q, rxen_q, tb8_q, rb8_q, ti_q, ri_q});
            SEL_DATA:   rd_data = REG_W'(rbuf_q);
            SEL_RELOAD: rd_data = reload_q;
            default:    rd_data = '0;
        endcase
    end

    AST_TI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ti_q && !wr_ctrl) |=> ti_q) else $error("transmit flag dropped"); // R6
    AST_RI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_q && !wr_ctrl) |=> ri_q) else $error("receive flag dropped"); // R7
    AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_q && (rx_done || sync_done)) |=> $stable(rbuf_q)) else $error("buffer overwritten"); // R9
    AST_RB8_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_q && rx_done) |=> $stable(rb8_q)) else $error("ninth bit overwritten"); // R9
endmodule

// File: tb/sport_ctrl_tb.sv
module sport_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        ser_in = 1'b1;
    logic        ser_out, sclk_o;

    int n_cmp = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    sport_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .ser_in(ser_in), .ser_out(ser_out),
        .sclk_o(sclk_o));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] v);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    // control word: mode[7:6] half[5] rxen[4] tb8[3]; flags written as given
    function automatic logic [15:0] cw(input int m, input bit h, input bit e, input bit t,
                                       input bit keep_ri, input bit keep_ti);
        return 16'((m << 6) | (int'(h) << 5) | (int'(e) << 4) | (int'(t) << 3) |
                   (int'(keep_ti) << 1) | int'(keep_ri));
    endfunction

    function automatic int bit_len(input int m, input bit h, input int rl);
        if (m == 2) return h ? 32 : 64;
        return 16 * (rl + 1);
    endfunction

    function automatic bit frame_bit(input logic [7:0] b, input bit b8, input bit nine, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return b[i-1];
        if (nine && i == 9) return b8;
        return 1'b1;
    endfunction

    task automatic wait_out(input logic v);
        while (ser_out !== v) @(negedge clk);
    endtask

    task automatic tx_check(input string tag, input logic [7:0] b, input bit b8, input bit nine, input int L);
        logic [15:0] v;
        int n = nine ? 11 : 10;
        wait_out(1'b0);
        repeat (L / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            chk(tag, 16'(ser_out), 16'(frame_bit(b, b8, nine, i)));
            if (i < n - 1) repeat (L) @(negedge clk);
        end
        repeat (L / 2 + 4) @(negedge clk);
        rd(2'd0, v);
        chk("R6 TI set after stop", 16'(v[1]), 16'd1);
    endtask

    task automatic rx_drive(input logic [7:0] b, input bit b8, input bit nine, input int L);
        int n = nine ? 11 : 10;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_in = frame_bit(b, b8, nine, i);
            repeat (L - 1) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b, b2;
        bit          b8;
        int          L, seed_dummy;
        seed_dummy = $urandom(32'd7345);

        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R1 ctrl reset", v, 16'h0000);
        rd(2'd1, v); chk("R1 data reset", v, 16'h0000);
        rd(2'd2, v); chk("R1 reload reset", v, 16'h0000);
        chk("R1 line idle", 16'(ser_out), 16'd1);
        chk("R1 sclk idle", 16'(sclk_o), 16'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 line after reset", 16'(ser_out), 16'd1);

        // mode 1 transmit, reload 1 -> 32 cycles per bit
        wr(2'd2, 16'd1);
        L = bit_len(1, 0, 1);
        for (int k = 0; k < 4; k++) begin
            b = 8'($urandom);
            wr(2'd0, cw(1, 0, 0, 0, 1, 0));
            wr(2'd1, {8'd0, b});
            tx_check("R3 R4 mode1 frame", b, 1'b0, 1'b0, L);
        end
        // R6: flag sticky, write of 1 leaves it, new frame leaves it
        wr(2'd0, cw(1, 0, 0, 0, 1, 1));
        rd(2'd0, v); chk("R6 TI after writing 1", 16'(v[1]), 16'd1);
        wr(2'd1, 16'h005A);
        wait_out(1'b0);
        rd(2'd0, v); chk("R6 TI kept during new frame", 16'(v[1]), 16'd1);
        wait_out(1'b1);
        repeat (12 * L) @(negedge clk);
        wr(2'd0, cw(1, 0, 0, 0, 1, 0));
        rd(2'd0, v); chk("R6 TI cleared by 0", 16'(v[1]), 16'd0);
        // write of 1 to cleared TI does not set it
        wr(2'd0, cw(1, 0, 0, 0, 1, 1));
        rd(2'd0, v); chk("R6 TI not set by 1", 16'(v[1]), 16'd0);

        // R12: second write during frame ignored
        b = 8'($urandom); b2 = ~b;
        wr(2'd1, {8'd0, b});
        repeat (5) @(negedge clk);
        wr(2'd1, {8'd0, b2});
        tx_check("R12 first byte sent", b, 1'b0, 1'b0, L);
        begin
            int moved = 0;
            for (int i = 0; i < 3 * L; i++) begin
                @(negedge clk);
                if (ser_out !== 1'b1) moved++;
            end
            chk("R12 no second frame", 16'(moved), 16'd0);
        end

        // reload 0 -> 16 cycles per bit
        wr(2'd2, 16'd0);
        wr(2'd0, cw(1, 0, 0, 0, 1, 0));
        b = 8'($urandom);
        wr(2'd1, {8'd0, b});
        tx_check("R4 reload0 16-cycle bits", b, 1'b0, 1'b0, 16);

        // mode 3 with ninth bit, reload 2
        wr(2'd2, 16'd2);
        for (int k = 0; k < 3; k++) begin
            b = 8'($urandom); b8 = 1'($urandom);
            wr(2'd0, cw(3, 0, 0, b8, 1, 0));
            wr(2'd1, {8'd0, b});
            tx_check("R3 mode3 ninth bit", b, b8, 1'b1, bit_len(3, 0, 2));
        end

        // mode 2 fixed rates
        for (int h = 0; h < 2; h++) begin
            b = 8'($urandom); b8 = 1'($urandom);
            wr(2'd0, cw(2, h[0], 0, b8, 1, 0));
            wr(2'd1, {8'd0, b});
            tx_check("R5 mode2 rate", b, b8, 1'b1, bit_len(2, h[0], 0));
        end

        // receive mode 1, reload 1
        wr(2'd2, 16'd1);
        L = bit_len(1, 0, 1);
        for (int k = 0; k < 3; k++) begin
            b = 8'($urandom);
            wr(2'd0, cw(1, 0, 1, 0, 0, 0));
            rx_drive(b, 1'b0, 1'b0, L);
            rd(2'd0, v); chk("R7 RI set", 16'(v[0]), 16'd1);
            chk("R8 RB8 is stop bit in mode1", 16'(v[2]), 16'd1);
            rd(2'd1, v); chk("R7 received byte", v, {8'd0, b});
        end

        // receive mode 3 ninth bit
        wr(2'd2, 16'd2);
        L = bit_len(3, 0, 2);
        for (int k = 0; k < 3; k++) begin
            b = 8'($urandom); b8 = 1'($urandom);
            wr(2'd0, cw(3, 0, 1, 0, 0, 0));
            rx_drive(b, b8, 1'b1, L);
            rd(2'd0, v); chk("R8 RB8 ninth bit", 16'(v[2]), 16'(b8));
            rd(2'd1, v); chk("R7 mode3 byte", v, {8'd0, b});
        end

        // R9 overrun: RI still set, new frame discarded
        b2 = b ^ 8'hFF;
        rx_drive(b2, ~b8, 1'b1, L);
        rd(2'd1, v); chk("R9 buffer kept", v, {8'd0, b});
        rd(2'd0, v); chk("R9 RB8 kept", 16'(v[2]), 16'(b8));

        // R10 false start then a valid frame
        wr(2'd0, cw(3, 0, 1, 0, 0, 0));
        @(negedge clk); ser_in = 1'b0;
        repeat (L / 4) @(negedge clk);
        ser_in = 1'b1;
        repeat (2 * L) @(negedge clk);
        rd(2'd0, v); chk("R10 no reception on glitch", 16'(v[0]), 16'd0);
        b = 8'($urandom);
        rx_drive(b, 1'b1, 1'b1, L);
        rd(2'd1, v); chk("R10 frame after glitch", v, {8'd0, b});

        // R11 receiver disabled
        wr(2'd0, cw(3, 0, 0, 0, 0, 0));
        rx_drive(~b, 1'b0, 1'b1, L);
        rd(2'd0, v); chk("R11 RI stays clear", 16'(v[0]), 16'd0);
        rd(2'd1, v); chk("R11 buffer unchanged", v, {8'd0, b});

        // R2 mode 0 shift, directed patterns then random
        for (int k = 0; k < 4; k++) begin
            logic [7:0] tb, rb;
            tb = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : 8'($urandom);
            rb = (k == 0) ? 8'hFE : 8'($urandom);
            wr(2'd0, cw(0, 0, 1, 0, 0, 0));
            ser_in = rb[0];
            wr(2'd1, {8'd0, tb});
            for (int i = 0; i < 8; i++) begin
                while (sclk_o !== 1'b1) @(negedge clk);
                chk("R2 sync data bit", 16'(ser_out), 16'(tb[i]));
                if (i < 7) begin
                    while (sclk_o !== 1'b0) @(negedge clk);
                    ser_in = rb[i+1];
                end
            end
            repeat (4) @(negedge clk);
            chk("R2 sclk idle high", 16'(sclk_o), 16'd1);
            rd(2'd0, v); chk("R2 TI after shift", 16'(v[1:0]), 16'd3);
            rd(2'd1, v); chk("R2 sync received byte", v, {8'd0, rb});
            ser_in = 1'b1;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule